// File: doc/BRIEF.md
# Programmable PDM Clock Divider

This block produces the pulse-duration-modulation clock from a square wave running at four times the RF carrier frequency. It is given the carrier frequency as a whole number of kHz and a band select. From these it works out an integer divisor N so that the divided clock lands near 130 kHz in the low band or near 260 kHz in the high band. It then divides the fast clock by N with a counter, giving an output whose high half is at most one input cycle longer than its low half.

A request carries the carrier value and the band select together on a valid/ready handshake. A request transfers on a rising edge of the fast clock when `load_valid` and `load_ready` are both high. `load_ready` stays low while a divisor is being worked out, which takes at most 66 cycles. A waiting requester must keep `load_valid` high and its data stable until it sees `load_ready`. The band select and carrier value are sampled only at the transfer. The computed divisor and its saturation flag are plain outputs. The divider itself always runs and never stalls. A new divisor replaces the active one only when the current output period ends, so the output never has a shortened high or low phase.

Top module: `pdm_clk_divider`

## Requirements
- R1: After reset `load_ready` is 1, `n_div` is 2 and `n_sat` is 0. The output runs with N = 2: one input cycle high, then one low.
- R2: A request transfers on an edge where `load_valid` and `load_ready` are both 1. `load_ready` is 0 from the next cycle until the divisor is known. A request held valid during that time is taken only after the earlier result has been delivered.
- R3: The divisor is floor(4 × `carrier_khz` / T). T is 130 when `hi_band` is 0 and 260 when `hi_band` is 1.
- R4: A quotient of 0 or 1 gives `n_div` = 2 and `n_sat` = 0.
- R5: A quotient above 63 gives `n_div` = 63 and `n_sat` = 1. A quotient of exactly 63 gives `n_div` = 63 and `n_sat` = 0.
- R6: With divisor N active, each output period starts high. The high phase lasts (N+1)/2 input cycles, rounded down, and the low phase lasts N/2 input cycles, rounded down.
- R7: A new divisor takes effect only at the end of the output period in progress. That period completes with the old high and low lengths.
- R8: Changes on `hi_band` or `carrier_khz` after a request has transferred do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk4x | input | 1 | Square wave at four times the carrier frequency; clocks the whole block |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_khz | input | 12 | Carrier frequency in kHz, part of the request |
| hi_band | input | 1 | Band select: 0 = low band (130 kHz target), 1 = high band (260 kHz target) |
| load_valid | input | 1 | Request valid |
| load_ready | output | 1 | Block can accept a request |
| n_div | output | 6 | Most recently computed divisor |
| n_sat | output | 1 | Computed quotient exceeded 63 and was saturated |
| pdm_clk | output | 1 | Divided PDM clock |

## Verification
The bench loads carrier values whose quotients fall just below, on and above the 63 ceiling, and below 2. An off-by-one in the subtraction loop or in the clamp would show up there as 62 or 64 wrapping to 0, or as a wrong flag. It measures high and low run lengths for both odd and even divisors. It switches from a long divisor to N = 2 partway through a high phase; a divider that swapped immediately would cut that period short. It also changes the band and carrier while a computation is running, and holds a second request through back-pressure. A design that sampled late or dropped the waiting request would report the wrong divisor.

// File: rtl/pdm_div_pkg.sv
package pdm_div_pkg;
  localparam int DIV_W_DEF = 6;
  localparam int N_MIN     = 2;

  typedef enum logic { BAND_LOW = 1'b0, BAND_HIGH = 1'b1 } band_e;
endpackage

// File: rtl/pdm_n_solver.sv
module pdm_n_solver
  import pdm_div_pkg::*;
#(
  parameter int CAR_W    = 12,
  parameter int N_W      = DIV_W_DEF,
  parameter int LOW_TGT  = 130,
  parameter int HIGH_TGT = 260
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAR_W-1:0] carrier_khz,
  input  logic             hi_band,
  input  logic             load_valid,
  output logic             load_ready,
  output logic [N_W:0]     quot,
  output logic             done
);
  localparam int REM_W = CAR_W + 2;
  localparam int QW    = N_W + 1;
  localparam int QLIM  = 1 << N_W;

  logic             busy;
  logic [REM_W-1:0] rem;
  logic [REM_W-1:0] tgt;
  band_e            band;

  assign load_ready = !busy;
  assign band       = band_e'(hi_band);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
      tgt  <= '0;
      quot <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load_valid) begin
          busy <= 1'b1;
          rem  <= {carrier_khz, 2'b00};
          tgt  <= (band == BAND_HIGH) ? REM_W'(HIGH_TGT) : REM_W'(LOW_TGT);
          quot <= '0;
        end
      end else if (rem >= tgt && quot != QW'(QLIM)) begin
        rem  <= rem - tgt;
        quot <= quot + QW'(1);
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R2: a transfer drops ready on the following cycle
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> !load_ready);

  // R5: the quotient never passes the saturation point
  p_quot_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quot <= QW'(QLIM));
endmodule

// File: rtl/pdm_n_clamp.sv
module pdm_n_clamp
  import pdm_div_pkg::*;
#(
  parameter int N_W = DIV_W_DEF
) (
  input  logic [N_W:0]   quot,
  output logic [N_W-1:0] n_val,
  output logic           sat
);
  localparam int QW    = N_W + 1;
  localparam int N_MAX = (1 << N_W) - 1;

  always_comb begin
    sat   = 1'b0;
    n_val = quot[N_W-1:0];
    if (quot > QW'(N_MAX)) begin
      sat   = 1'b1;
      n_val = N_W'(N_MAX);
    end else if (quot < QW'(N_MIN)) begin
      n_val = N_W'(N_MIN);
    end
  end

  // R4: the clamped value never falls below the minimum divisor
  always_comb begin
    p_floor_r4: assert (n_val >= N_W'(N_MIN));
  end
endmodule

// File: rtl/pdm_period_ctr.sv
module pdm_period_ctr
  import pdm_div_pkg::*;
#(
  parameter int N_W = DIV_W_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           n_load,
  input  logic [N_W-1:0] n_in,
  output logic           pdm_clk
);
  logic [N_W-1:0] cur_n, pend_n, cnt;
  logic           pend_v;
  logic           last;
  logic [N_W-1:0] nxt_n, nxt_cnt;
  logic [N_W:0]   half;

  always_comb begin
    last    = (cnt == cur_n - N_W'(1));
    nxt_n   = (last && pend_v) ? pend_n : cur_n;
    nxt_cnt = last ? '0 : cnt + N_W'(1);
    half    = ({1'b0, nxt_n} + (N_W+1)'(1)) >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n   <= N_W'(N_MIN);
      pend_n  <= N_W'(N_MIN);
      pend_v  <= 1'b0;
      cnt     <= '0;
      pdm_clk <= 1'b1;
    end else begin
      cnt     <= nxt_cnt;
      cur_n   <= nxt_n;
      pdm_clk <= ({1'b0, nxt_cnt} < half);
      if (n_load) begin
        pend_n <= n_in;
        pend_v <= 1'b1;
      end else if (last) begin
        pend_v <= 1'b0;
      end
    end
  end

  // R7: the active divisor only changes as a new period begins
  p_swap_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_n) |-> (cnt == '0));

  // R6: every period opens with the high phase
  p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> pdm_clk);

  // R6: the phase counter stays inside the active period
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_n);
endmodule

// File: rtl/pdm_clk_divider.sv
module pdm_clk_divider
  import pdm_div_pkg::*;
#(
  parameter int CAR_W    = 12,
  parameter int N_W      = DIV_W_DEF,
  parameter int LOW_TGT  = 130,
  parameter int HIGH_TGT = 260
) (
  input  logic             clk4x,
  input  logic             rst_n,
  input  logic [CAR_W-1:0] carrier_khz,
  input  logic             hi_band,
  input  logic             load_valid,
  output logic             load_ready,
  output logic [N_W-1:0]   n_div,
  output logic             n_sat,
  output logic             pdm_clk
);
  localparam int N_MAX = (1 << N_W) - 1;

  logic [N_W:0]   quot;
  logic           done;
  logic [N_W-1:0] n_val;
  logic           sat;

  pdm_n_solver #(
    .CAR_W(CAR_W), .N_W(N_W), .LOW_TGT(LOW_TGT), .HIGH_TGT(HIGH_TGT)
  ) u_solver (
    .clk(clk4x), .rst_n(rst_n), .carrier_khz(carrier_khz), .hi_band(hi_band),
    .load_valid(load_valid), .load_ready(load_ready), .quot(quot), .done(done)
  );

  pdm_n_clamp #(.N_W(N_W)) u_clamp (
    .quot(quot), .n_val(n_val), .sat(sat)
  );

  always_ff @(posedge clk4x or negedge rst_n) begin
    if (!rst_n) begin
      n_div <= N_W'(N_MIN);
      n_sat <= 1'b0;
    end else if (done) begin
      n_div <= n_val;
      n_sat <= sat;
    end
  end

  pdm_period_ctr #(.N_W(N_W)) u_ctr (
    .clk(clk4x), .rst_n(rst_n), .n_load(done), .n_in(n_val), .pdm_clk(pdm_clk)
  );

  // R5: the saturation flag only accompanies the largest divisor
  p_sat_pins_r5: assert property (@(posedge clk4x) disable iff (!rst_n)
    n_sat |-> (n_div == N_W'(N_MAX)));

  // R4: the presented divisor is never below two
  p_min_div_r4: assert property (@(posedge clk4x) disable iff (!rst_n)
    n_div >= N_W'(N_MIN));
endmodule

// File: tb/pdm_clk_divider_tb.sv
module pdm_clk_divider_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] carrier_khz = '0;
  logic        hi_band = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [5:0]  n_div;
  logic        n_sat;
  logic        pdm_clk;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_clk_divider dut_i (
    .clk4x(clk), .rst_n(rst_n), .carrier_khz(carrier_khz), .hi_band(hi_band),
    .load_valid(load_valid), .load_ready(load_ready), .n_div(n_div),
    .n_sat(n_sat), .pdm_clk(pdm_clk)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_n(int fc, bit band);
    int q;
    q = (4 * fc) / (band ? 260 : 130);
    if (q < 2) return 2;
    if (q > 63) return 63;
    return q;
  endfunction

  function automatic int exp_sat(int fc, bit band);
    return ((4 * fc) / (band ? 260 : 130)) > 63 ? 1 : 0;
  endfunction

  task automatic wait_rise();
    logic prev;
    prev = pdm_clk;
    forever begin
      @(negedge clk);
      if (!prev && pdm_clk) break;
      prev = pdm_clk;
    end
  endtask

  task automatic measure_run(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (pdm_clk) begin hi++; @(negedge clk); end
    while (!pdm_clk) begin lo++; @(negedge clk); end
  endtask

  task automatic do_load(int fc, bit band);
    while (!load_ready) @(negedge clk);
    carrier_khz = 12'(fc);
    hi_band     = band;
    load_valid  = 1'b1;
    @(negedge clk);
    load_valid  = 1'b0;
    while (!load_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    int hi, lo;
    chk("R1", "ready after reset", int'(load_ready), 1);
    chk("R1", "n_div after reset", int'(n_div), 2);
    chk("R1", "n_sat after reset", int'(n_sat), 0);
    wait_rise();
    measure_run(hi, lo);
    chk("R1", "reset high run", hi, 1);
    chk("R1", "reset low run", lo, 1);
  endtask

  task automatic t_calc(string req, int fc, bit band);
    int hi, lo, n;
    n = exp_n(fc, band);
    do_load(fc, band);
    chk(req, $sformatf("n_div fc=%0d band=%0d", fc, band), int'(n_div), n);
    chk(req, $sformatf("n_sat fc=%0d band=%0d", fc, band), int'(n_sat), exp_sat(fc, band));
    wait_rise();
    wait_rise();
    measure_run(hi, lo);
    chk("R6", $sformatf("high run N=%0d", n), hi, (n + 1) / 2);
    chk("R6", $sformatf("low run N=%0d", n), lo, n / 2);
  endtask

  task automatic t_backpressure();
    while (!load_ready) @(negedge clk);
    carrier_khz = 12'd2000;
    hi_band     = 1'b0;
    load_valid  = 1'b1;
    @(negedge clk);
    carrier_khz = 12'd300;
    hi_band     = 1'b1;
    chk("R2", "ready low while computing", int'(load_ready), 0);
    while (!load_ready) @(negedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    chk("R2", "first result delivered", int'(n_div), exp_n(2000, 1'b0));
    chk("R2", "held request taken", int'(load_ready), 0);
    while (!load_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R2", "second result", int'(n_div), exp_n(300, 1'b1));
  endtask

  task automatic t_mode_ignored();
    while (!load_ready) @(negedge clk);
    carrier_khz = 12'd1000;
    hi_band     = 1'b1;
    load_valid  = 1'b1;
    @(negedge clk);
    load_valid  = 1'b0;
    hi_band     = 1'b0;
    carrier_khz = 12'd10;
    while (!load_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8", "late band/carrier change ignored", int'(n_div), exp_n(1000, 1'b1));
  endtask

  task automatic t_no_runt();
    int hi, lo;
    do_load(2048, 1'b0);
    wait_rise();
    wait_rise();
    fork
      measure_run(hi, lo);
      begin
        carrier_khz = 12'd65;
        hi_band     = 1'b0;
        load_valid  = 1'b1;
        @(negedge clk);
        load_valid  = 1'b0;
      end
    join
    chk("R7", "old high run kept", hi, 32);
    chk("R7", "old low run kept", lo, 31);
    measure_run(hi, lo);
    chk("R7", "new high run", hi, 1);
    chk("R7", "new low run", lo, 1);
    chk("R7", "n_div after swap", int'(n_div), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_calc("R3", 300, 1'b0);
    t_calc("R3", 300, 1'b1);
    t_calc("R3", 1000, 1'b1);
    t_calc("R3", 2047, 1'b0);
    t_calc("R4", 10, 1'b0);
    t_calc("R4", 100, 1'b1);
    t_calc("R5", 2048, 1'b0);
    t_calc("R5", 4095, 1'b1);
    t_calc("R5", 2080, 1'b0);
    t_backpressure();
    t_mode_ignored();
    t_no_runt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule